// File: doc/BRIEF.md
# Hard-Disk Task-File and Seek Sequencer

This block is the host-facing register file and command sequencer of a hard-disk controller. The host reaches it through byte-wide registers selected by a 3-bit address. These registers hold a sector count, a sector number, a cylinder address split over a low and a high byte, a size/drive/head byte and a write-precompensation byte. Address 7 takes commands on write and returns status on read. Address 1 returns the error register on read.

Restore and seek commands produce single-cycle step pulses and a direction line, spaced at the rate coded in the command. The block tracks the cylinder the heads sit on. Read, write and format commands raise a data request for each sector. The host answers each sector with a one-cycle acknowledge, and in multi-sector mode the block counts the sector count down. Serial encoding, CRC/ECC and all drive timing other than stepping belong to other blocks.

Register map: 1 error (read) / precompensation (write), 2 sector count, 3 sector number, 4 cylinder low, 5 cylinder high, 6 size/drive/head, 7 status (read) / command (write). Other addresses read as zero.

Top module: `hdc_unit`

## Requirements
- R1: After reset, status reads with only bit 6 (drive ready) and bit 5 (write fault) taken from their inputs. The error register, sector count and sector number read zero, and step_o, drq_o and irq_o are low.
- R2: The sector count, sector number, cylinder low and size/drive/head registers read back what was written. Cylinder high keeps only bits 1:0 and reads zeros above them. A write to address 1 appears on precomp_o. Status bit 2 reads 0.
- R3: Seek (0111_rrrr) emits exactly |target − current| step pulses. The target is {cylinder high, cylinder low}. dir_o is 1 when the target is above the current cylinder and 0 otherwise. At the end, status bit 4 (seek complete) is 1 and bit 1 (command in progress) is 0. When target equals current, the seek completes with no pulses.
- R4: Step pulses are one cycle wide. The spacing is 35·CLKS_PER_US cycles for rate code 0 and code·500·CLKS_PER_US cycles for codes 1–15. The first pulse comes one spacing after the command write.
- R5: Restore (0001_rrrr) steps with dir_o = 0 until track0_i is seen, then sets the current cylinder to 0 and sets seek complete. If track0_i is already high, no pulses are issued.
- R6: If restore has issued MAX_STEPS pulses without seeing track0_i, it ends with error bit 1 set, status bit 0 set and seek complete clear.
- R7: While stepping, status bit 7 (busy) and bit 1 are 1. A command written while a command is in progress is ignored.
- R8: Read sector (0010_i_m_00) and write sector (0011_0_m_00) raise drq_o and status bit 3 with busy clear. Format (0101_0000) does the same for one sector. In single-sector mode (m = 0), one xfer_ack_i ends the command and leaves the sector count unchanged.
- R9: With m = 1, each acknowledge decrements the sector count and increments the sector number. The command ends on the acknowledge that brings the count to zero.
- R10: irq_o is set at the end of every command, except a read with i = 0. That read instead sets irq_o each time a data request is raised. Reading status clears irq_o.
- R11: Any code outside the listed encodings sets error bit 2 (aborted) and status bit 0, raises irq_o and causes no stepping or data request. Any accepted command clears the error register.
- R12: Scan ID (0100_0000) loads the cylinder low/high registers with the current cylinder and completes with irq_o.
- R13: Status bit 6 follows drive_ready_i and bit 5 follows write_fault_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 3 | Register select |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (status read clears irq) |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i |
| xfer_ack_i | input | 1 | Host finished one sector |
| track0_i | input | 1 | Heads at cylinder 0 |
| drive_ready_i | input | 1 | Drive ready line |
| write_fault_i | input | 1 | Drive write fault line |
| step_o | output | 1 | Step pulse |
| dir_o | output | 1 | Step direction, 1 = toward higher cylinders |
| drq_o | output | 1 | Data request |
| irq_o | output | 1 | Interrupt request |
| precomp_o | output | 8 | Write-precompensation cylinder value |

## Verification
A wrong tracked cylinder does not show at once. It shows on the next seek as a wrong number of step pulses or a wrong direction, and after a scan ID as wrong cylinder bytes. Errors in the step timer show up as wrong spacing within one step interval. Errors in the sector counter show in the count and number registers right after each acknowledge, and as a data request that drops too early or stays up too long. The bench therefore chains its commands so that each one checks the state the previous one left behind.

// File: rtl/hdc_pkg.sv
package hdc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_STEP, ST_XFER} state_e;
  typedef enum logic [2:0] {
    OP_BAD, OP_RESTORE, OP_SEEK, OP_READ, OP_WRITE, OP_SCAN, OP_FORMAT
  } op_e;

  localparam logic [2:0] ADR_ERR  = 3'd1;
  localparam logic [2:0] ADR_CNT  = 3'd2;
  localparam logic [2:0] ADR_NUM  = 3'd3;
  localparam logic [2:0] ADR_CYLL = 3'd4;
  localparam logic [2:0] ADR_CYLH = 3'd5;
  localparam logic [2:0] ADR_SDH  = 3'd6;
  localparam logic [2:0] ADR_CMD  = 3'd7;

  localparam int ERR_TRK0  = 1;
  localparam int ERR_ABORT = 2;
endpackage

// File: rtl/hdc_cmd_decode.sv
module hdc_cmd_decode
  import hdc_pkg::*;
(
  input  logic [7:0] cmd_i,
  output op_e        op_o,
  output logic [3:0] rate_o,
  output logic       multi_o,
  output logic       irq_each_o
);
  always_comb begin
    op_o = OP_BAD;
    unique case (cmd_i[7:4])
      4'h1: op_o = OP_RESTORE;
      4'h7: op_o = OP_SEEK;
      4'h2: if (cmd_i[1:0] == 2'b00) op_o = OP_READ;
      4'h3: if (cmd_i[3] == 1'b0 && cmd_i[1:0] == 2'b00) op_o = OP_WRITE;
      4'h4: if (cmd_i[3:0] == 4'h0) op_o = OP_SCAN;
      4'h5: if (cmd_i[3:0] == 4'h0) op_o = OP_FORMAT;
      default: op_o = OP_BAD;
    endcase
  end

  assign rate_o     = cmd_i[3:0];
  assign multi_o    = cmd_i[2] && (op_o == OP_READ || op_o == OP_WRITE);
  assign irq_each_o = (op_o == OP_READ) && !cmd_i[3];
endmodule

// File: rtl/hdc_step_timer.sv
module hdc_step_timer #(
  parameter int unsigned CLKS_PER_US = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       run_i,
  input  logic [3:0] rate_i,
  output logic       tick_o
);
  localparam int unsigned FAST = 35 * CLKS_PER_US;
  localparam int unsigned UNIT = 500 * CLKS_PER_US;
  localparam int unsigned MAXI = 15 * UNIT;
  localparam int unsigned TW   = $clog2(MAXI + 1);

  logic [TW-1:0] cnt_q;
  logic [3:0]    rate_q;

  function automatic logic [TW-1:0] interval(input logic [3:0] r);
    return (r == 4'd0) ? TW'(FAST) : TW'(r) * TW'(UNIT);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      rate_q <= '0;
    end else if (start_i) begin
      rate_q <= rate_i;
      cnt_q  <= interval(rate_i) - TW'(1);
    end else if (run_i) begin
      cnt_q <= (cnt_q == '0) ? interval(rate_q) - TW'(1) : cnt_q - TW'(1);
    end
  end

  assign tick_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/hdc_taskfile.sv
module hdc_taskfile
  import hdc_pkg::*;
#(
  parameter int CYL_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [2:0]       addr_i,
  input  logic [7:0]       wdata_i,
  input  logic             sec_step_i,
  input  logic             cyl_load_i,
  input  logic [CYL_W-1:0] cyl_val_i,
  output logic [7:0]       sec_cnt_o,
  output logic [7:0]       sec_num_o,
  output logic [CYL_W-1:0] cyl_o,
  output logic [7:0]       sdh_o,
  output logic [7:0]       precomp_o
);
  localparam int HI_W = CYL_W - 8;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_cnt_o <= '0;
      sec_num_o <= '0;
      cyl_o     <= '0;
      sdh_o     <= '0;
      precomp_o <= '0;
    end else begin
      if (wr_i) begin
        unique case (addr_i)
          ADR_ERR:  precomp_o <= wdata_i;
          ADR_CNT:  sec_cnt_o <= wdata_i;
          ADR_NUM:  sec_num_o <= wdata_i;
          ADR_CYLL: cyl_o[7:0] <= wdata_i;
          ADR_CYLH: cyl_o[CYL_W-1:8] <= wdata_i[HI_W-1:0];
          ADR_SDH:  sdh_o <= wdata_i;
          default: ;
        endcase
      end
      if (sec_step_i) begin
        sec_cnt_o <= sec_cnt_o - 8'd1;
        sec_num_o <= sec_num_o + 8'd1;
      end
      if (cyl_load_i) cyl_o <= cyl_val_i;
    end
  end
endmodule

// File: rtl/hdc_unit.sv
module hdc_unit
  import hdc_pkg::*;
#(
  parameter int          CYL_W       = 10,
  parameter int unsigned CLKS_PER_US = 1,
  parameter int unsigned MAX_STEPS   = 1024
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] reg_addr_i,
  input  logic       reg_wr_i,
  input  logic       reg_rd_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  input  logic       xfer_ack_i,
  input  logic       track0_i,
  input  logic       drive_ready_i,
  input  logic       write_fault_i,
  output logic       step_o,
  output logic       dir_o,
  output logic       drq_o,
  output logic       irq_o,
  output logic [7:0] precomp_o
);
  localparam int PCW = $clog2(MAX_STEPS + 1);

  state_e           state_q;
  logic [CYL_W-1:0] cur_cyl_q, steps_left_q;
  logic [PCW-1:0]   pulses_q;
  logic             is_restore_q, multi_q, irq_each_q;
  logic [7:0]       err_q;
  logic             seek_done_q, irq_q, step_q, dir_q;

  op_e              dec_op;
  logic [3:0]       dec_rate;
  logic             dec_multi, dec_irq_each;
  logic [7:0]       sec_cnt, sec_num, sdh;
  logic [CYL_W-1:0] target;
  logic             tick, accept, sec_step, xfer_last, cip;
  logic             go_up;
  logic [CYL_W-1:0] diff;
  logic [7:0]       status;

  assign accept    = reg_wr_i && (reg_addr_i == ADR_CMD) && (state_q == ST_IDLE);
  assign sec_step  = (state_q == ST_XFER) && xfer_ack_i && multi_q;
  assign xfer_last = !multi_q || (sec_cnt == 8'd1);
  assign go_up     = target > cur_cyl_q;
  assign diff      = go_up ? target - cur_cyl_q : cur_cyl_q - target;
  assign cip       = (state_q != ST_IDLE);

  hdc_cmd_decode u_dec (
    .cmd_i      (reg_wdata_i),
    .op_o       (dec_op),
    .rate_o     (dec_rate),
    .multi_o    (dec_multi),
    .irq_each_o (dec_irq_each)
  );

  hdc_taskfile #(.CYL_W(CYL_W)) u_tf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (reg_wr_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .sec_step_i (sec_step),
    .cyl_load_i (accept && dec_op == OP_SCAN),
    .cyl_val_i  (cur_cyl_q),
    .sec_cnt_o  (sec_cnt),
    .sec_num_o  (sec_num),
    .cyl_o      (target),
    .sdh_o      (sdh),
    .precomp_o  (precomp_o)
  );

  hdc_step_timer #(.CLKS_PER_US(CLKS_PER_US)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept),
    .run_i   (state_q == ST_STEP),
    .rate_i  (dec_rate),
    .tick_o  (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      cur_cyl_q    <= '0;
      steps_left_q <= '0;
      pulses_q     <= '0;
      is_restore_q <= 1'b0;
      multi_q      <= 1'b0;
      irq_each_q   <= 1'b0;
      err_q        <= '0;
      seek_done_q  <= 1'b0;
      irq_q        <= 1'b0;
      step_q       <= 1'b0;
      dir_q        <= 1'b0;
    end else begin
      step_q <= 1'b0;
      if (reg_rd_i && reg_addr_i == ADR_CMD) irq_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          err_q <= '0;
          unique case (dec_op)
            OP_RESTORE: begin
              seek_done_q  <= 1'b0;
              dir_q        <= 1'b0;
              is_restore_q <= 1'b1;
              pulses_q     <= '0;
              if (track0_i) begin
                cur_cyl_q   <= '0;
                seek_done_q <= 1'b1;
                irq_q       <= 1'b1;
              end else begin
                state_q <= ST_STEP;
              end
            end
            OP_SEEK: begin
              seek_done_q  <= 1'b0;
              is_restore_q <= 1'b0;
              dir_q        <= go_up;
              steps_left_q <= diff;
              if (diff == '0) begin
                seek_done_q <= 1'b1;
                irq_q       <= 1'b1;
              end else begin
                state_q <= ST_STEP;
              end
            end
            OP_READ, OP_WRITE, OP_FORMAT: begin
              multi_q    <= dec_multi;
              irq_each_q <= dec_irq_each;
              state_q    <= ST_XFER;
              if (dec_irq_each) irq_q <= 1'b1;
            end
            OP_SCAN: irq_q <= 1'b1;
            default: begin
              err_q[ERR_ABORT] <= 1'b1;
              irq_q            <= 1'b1;
            end
          endcase
        end
        ST_STEP: if (tick) begin
          if (is_restore_q) begin
            if (track0_i) begin
              cur_cyl_q   <= '0;
              seek_done_q <= 1'b1;
              irq_q       <= 1'b1;
              state_q     <= ST_IDLE;
            end else if (pulses_q == PCW'(MAX_STEPS)) begin
              err_q[ERR_TRK0] <= 1'b1;
              irq_q           <= 1'b1;
              state_q         <= ST_IDLE;
            end else begin
              step_q    <= 1'b1;
              pulses_q  <= pulses_q + PCW'(1);
              cur_cyl_q <= cur_cyl_q - CYL_W'(1);
            end
          end else begin
            step_q       <= 1'b1;
            cur_cyl_q    <= dir_q ? cur_cyl_q + CYL_W'(1) : cur_cyl_q - CYL_W'(1);
            steps_left_q <= steps_left_q - CYL_W'(1);
            if (steps_left_q == CYL_W'(1)) begin
              seek_done_q <= 1'b1;
              irq_q       <= 1'b1;
              state_q     <= ST_IDLE;
            end
          end
        end
        ST_XFER: if (xfer_ack_i) begin
          if (xfer_last) begin
            state_q <= ST_IDLE;
            if (!irq_each_q) irq_q <= 1'b1;
          end else if (irq_each_q) begin
            irq_q <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign status = {state_q == ST_STEP, drive_ready_i, write_fault_i, seek_done_q,
                   state_q == ST_XFER, 1'b0, cip, |err_q};

  always_comb begin
    unique case (reg_addr_i)
      ADR_ERR:  reg_rdata_o = err_q;
      ADR_CNT:  reg_rdata_o = sec_cnt;
      ADR_NUM:  reg_rdata_o = sec_num;
      ADR_CYLL: reg_rdata_o = target[7:0];
      ADR_CYLH: reg_rdata_o = 8'(target[CYL_W-1:8]);
      ADR_SDH:  reg_rdata_o = sdh;
      ADR_CMD:  reg_rdata_o = status;
      default:  reg_rdata_o = 8'h00;
    endcase
  end

  assign step_o = step_q;
  assign dir_o  = dir_q;
  assign drq_o  = (state_q == ST_XFER);
  assign irq_o  = irq_q;
endmodule

// File: rtl/hdc_unit_chk.sv
module hdc_unit_chk #(
  parameter int CYL_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       reg_addr_i,
  input logic             reg_wr_i,
  input logic             reg_rd_i,
  input logic [7:0]       reg_rdata_o,
  input logic             xfer_ack_i,
  input logic             step_o,
  input logic             drq_o,
  input logic             irq_o,
  input logic [7:0]       sec_cnt,
  input logic             multi,
  input logic             cip,
  input logic [CYL_W-1:0] cur_cyl
);
  a_r4_step_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |=> !step_o);

  a_r3_step_moves_cyl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> cur_cyl != $past(cur_cyl));

  a_r8_drq_from_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drq_o) |-> $past(reg_wr_i && reg_addr_i == 3'd7));

  a_r8_drq_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drq_o && reg_addr_i == 3'd7) |-> !reg_rdata_o[7]);

  a_r9_count_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drq_o && xfer_ack_i && multi && !reg_wr_i) |=> sec_cnt == $past(sec_cnt) - 8'd1);

  a_r10_irq_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == 3'd7 && !reg_wr_i && !cip) |=> !irq_o);
endmodule

bind hdc_unit hdc_unit_chk #(.CYL_W(CYL_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_addr_i  (reg_addr_i),
  .reg_wr_i    (reg_wr_i),
  .reg_rd_i    (reg_rd_i),
  .reg_rdata_o (reg_rdata_o),
  .xfer_ack_i  (xfer_ack_i),
  .step_o      (step_o),
  .drq_o       (drq_o),
  .irq_o       (irq_o),
  .sec_cnt     (sec_cnt),
  .multi       (multi_q),
  .cip         (cip),
  .cur_cyl     (cur_cyl_q)
);

// File: tb/tb_hdc_unit.sv
module tb_hdc_unit;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] reg_addr_i = 3'd0;
  logic       reg_wr_i = 1'b0, reg_rd_i = 1'b0;
  logic [7:0] reg_wdata_i = 8'h00;
  logic [7:0] reg_rdata_o, precomp_o;
  logic       xfer_ack_i = 1'b0;
  logic       drive_ready_i = 1'b1, write_fault_i = 1'b0;
  logic       track0_i, step_o, dir_o, drq_o, irq_o;

  int n_chk = 0, n_bad = 0;
  int cyc = 0, wr_cyc = 0, cmd_cyc = 0;
  int pos = 0, pulses = 0, first_t = 0, second_t = 0;
  bit t0_stuck = 1'b0;
  logic [7:0] s, v;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign track0_i = !t0_stuck && (pos == 0);

  always @(negedge clk) if (step_o) begin
    pulses = pulses + 1;
    if (pulses == 1) first_t = cyc;
    if (pulses == 2) second_t = cyc;
    pos = dir_o ? pos + 1 : pos - 1;
  end

  hdc_unit dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_addr_i(reg_addr_i), .reg_wr_i(reg_wr_i),
    .reg_rd_i(reg_rd_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .xfer_ack_i(xfer_ack_i), .track0_i(track0_i), .drive_ready_i(drive_ready_i),
    .write_fault_i(write_fault_i), .step_o(step_o), .dir_o(dir_o), .drq_o(drq_o),
    .irq_o(irq_o), .precomp_o(precomp_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
    @(negedge clk);
    reg_wr_i = 1'b0;
    wr_cyc = cyc;
  endtask

  task automatic rd(input logic [2:0] a, input bit clr, output logic [7:0] d);
    @(negedge clk);
    reg_addr_i = a; reg_rd_i = clr;
    #1 d = reg_rdata_o;
    if (clr) begin
      @(negedge clk);
      reg_rd_i = 1'b0;
    end
  endtask

  task automatic cmd(input logic [7:0] c);
    pulses = 0;
    wr(3'd7, c);
    cmd_cyc = wr_cyc;
  endtask

  task automatic ack();
    @(negedge clk); xfer_ack_i = 1'b1;
    @(negedge clk); xfer_ack_i = 1'b0;
  endtask

  task automatic clr_irq();
    logic [7:0] t;
    rd(3'd7, 1'b1, t);
  endtask

  task automatic wait_idle(input int lim);
    logic [7:0] t;
    int n = 0;
    do begin
      rd(3'd7, 1'b0, t);
      n++;
    end while (t[1] && n < lim);
    chk(!t[1], "R7 command never finished", t, 0);
  endtask

  task automatic t_reset();
    rd(3'd7, 1'b0, s); eq("R1 status", s, 8'h40);
    rd(3'd1, 1'b0, v); eq("R1 error", v, 0);
    rd(3'd2, 1'b0, v); eq("R1 count", v, 0);
    rd(3'd3, 1'b0, v); eq("R1 number", v, 0);
    eq("R1 outputs {irq,drq,step}", {irq_o, drq_o, step_o}, 0);
  endtask

  task automatic t_regs();
    wr(3'd2, 8'h12); wr(3'd3, 8'h34); wr(3'd4, 8'hAB); wr(3'd5, 8'hFF);
    wr(3'd6, 8'hB5); wr(3'd1, 8'h77);
    rd(3'd2, 1'b0, v); eq("R2 count", v, 8'h12);
    rd(3'd3, 1'b0, v); eq("R2 number", v, 8'h34);
    rd(3'd4, 1'b0, v); eq("R2 cyl low", v, 8'hAB);
    rd(3'd5, 1'b0, v); eq("R2 cyl high masked", v, 8'h03);
    rd(3'd6, 1'b0, v); eq("R2 sdh", v, 8'hB5);
    eq("R2 precomp_o", precomp_o, 8'h77);
    rd(3'd7, 1'b0, s); eq("R2 status bit2", s[2], 0);
    wr(3'd5, 8'h00);
  endtask

  task automatic t_seek();
    int t0;
    wr(3'd4, 8'd5);
    cmd(8'h70);
    t0 = cmd_cyc;
    rd(3'd7, 1'b0, s); eq("R7 busy+cip while stepping", {s[7], s[1]}, 2'b11);
    wr(3'd7, 8'h10);
    wait_idle(1000);
    eq("R3 pulse count up", pulses, 5);
    eq("R3 dir up", dir_o, 1);
    eq("R7 ignored restore: position", pos, 5);
    eq("R4 first delay code0", first_t - t0, 35);
    eq("R4 spacing code0", second_t - first_t, 35);
    rd(3'd7, 1'b0, s); eq("R3 seek complete", s[4], 1);
    eq("R10 irq after seek", irq_o, 1);
    clr_irq(); eq("R10 irq cleared by status read", irq_o, 0);
    wr(3'd4, 8'd2); cmd(8'h70); wait_idle(1000);
    eq("R3 pulse count down", pulses, 3);
    eq("R3 dir down", dir_o, 0);
    cmd(8'h70); wait_idle(100);
    eq("R3 zero-distance seek pulses", pulses, 0);
    rd(3'd7, 1'b0, s); eq("R3 zero-distance seek complete", s[4], 1);
  endtask

  task automatic t_rate();
    wr(3'd4, 8'd4); cmd(8'h71); wait_idle(3000);
    eq("R4 pulses code1", pulses, 2);
    eq("R4 first delay code1", first_t - cmd_cyc, 500);
    eq("R4 spacing code1", second_t - first_t, 500);
  endtask

  task automatic t_restore();
    cmd(8'h10); wait_idle(1000);
    eq("R5 restore pulses", pulses, 4);
    eq("R5 restore dir", dir_o, 0);
    eq("R5 position", pos, 0);
    rd(3'd7, 1'b0, s); eq("R5 seek complete", s[4], 1);
    wr(3'd4, 8'd3); cmd(8'h70); wait_idle(1000);
    eq("R5 cylinder zero after restore", pulses, 3);
    cmd(8'h10); wait_idle(1000);
    cmd(8'h10); wait_idle(100);
    eq("R5 restore at track0 no pulses", pulses, 0);
  endtask

  task automatic t_scan();
    wr(3'd4, 8'h03); wr(3'd5, 8'h01); cmd(8'h70); wait_idle(20000);
    eq("R3 long seek pulses", pulses, 259);
    wr(3'd4, 8'h00); wr(3'd5, 8'h00);
    clr_irq();
    cmd(8'h40);
    rd(3'd4, 1'b0, v); eq("R12 scan cyl low", v, 8'h03);
    rd(3'd5, 1'b0, v); eq("R12 scan cyl high", v, 8'h01);
    eq("R12 scan irq", irq_o, 1);
  endtask

  task automatic t_timeout();
    t0_stuck = 1'b1;
    cmd(8'h10); wait_idle(40000);
    eq("R6 pulses before giving up", pulses, 1024);
    rd(3'd1, 1'b0, v); eq("R6 track0 error", v, 8'h02);
    rd(3'd7, 1'b0, s); eq("R6 status {seek done,err}", {s[4], s[0]}, 2'b01);
    t0_stuck = 1'b0;
    pos = 0;
    cmd(8'h10); wait_idle(100);
  endtask

  task automatic t_read_single();
    wr(3'd2, 8'd5); clr_irq();
    cmd(8'h28);
    rd(3'd7, 1'b0, s);
    eq("R8 status drq/busy/cip", {s[7], s[3], s[1]}, 3'b011);
    eq("R8 drq_o", drq_o, 1);
    eq("R10 no irq at drq with i=1", irq_o, 0);
    ack();
    eq("R8 drq dropped", drq_o, 0);
    eq("R10 irq at end with i=1", irq_o, 1);
    rd(3'd2, 1'b0, v); eq("R8 count unchanged", v, 5);
    rd(3'd7, 1'b0, s); eq("R8 cip clear", s[1], 0);
  endtask

  task automatic t_read_multi();
    wr(3'd2, 8'd3); wr(3'd3, 8'd7); clr_irq();
    cmd(8'h24);
    eq("R10 irq at drq with i=0", irq_o, 1);
    clr_irq();
    ack();
    rd(3'd2, 1'b0, v); eq("R9 count after 1", v, 2);
    rd(3'd3, 1'b0, v); eq("R9 number after 1", v, 8);
    eq("R9 drq held", drq_o, 1);
    eq("R10 irq per sector i=0", irq_o, 1);
    clr_irq(); ack(); clr_irq(); ack();
    rd(3'd2, 1'b0, v); eq("R9 count end", v, 0);
    rd(3'd3, 1'b0, v); eq("R9 number end", v, 10);
    eq("R9 drq end", drq_o, 0);
    eq("R10 no end irq i=0", irq_o, 0);
  endtask

  task automatic t_write_multi();
    wr(3'd2, 8'd2); clr_irq();
    cmd(8'h34);
    eq("R8 write drq", drq_o, 1);
    eq("R10 write no early irq", irq_o, 0);
    ack();
    rd(3'd2, 1'b0, v); eq("R9 write count", v, 1);
    eq("R10 write mid irq", irq_o, 0);
    ack();
    eq("R10 write end irq", irq_o, 1);
    eq("R9 write drq end", drq_o, 0);
  endtask

  task automatic t_invalid();
    logic [7:0] bad [5] = '{8'h00, 8'h2A, 8'h38, 8'h41, 8'hFF};
    foreach (bad[k]) begin
      clr_irq();
      cmd(bad[k]);
      rd(3'd1, 1'b0, v); eq("R11 aborted bit", v, 8'h04);
      rd(3'd7, 1'b0, s); eq("R11 status {drq,cip,err}", {s[3], s[1], s[0]}, 3'b001);
      eq("R11 irq", irq_o, 1);
      repeat (40) @(negedge clk);
      eq("R11 no stepping", pulses, 0);
    end
    cmd(8'h50);
    eq("R8 format drq", drq_o, 1);
    rd(3'd1, 1'b0, v); eq("R11 error cleared by command", v, 0);
    ack();
    rd(3'd7, 1'b0, s); eq("R8 format done", s[1], 0);
  endtask

  task automatic t_lines();
    drive_ready_i = 1'b0; write_fault_i = 1'b1;
    rd(3'd7, 1'b0, s); eq("R13 ready/fault bits", {s[6], s[5]}, 2'b01);
    drive_ready_i = 1'b1; write_fault_i = 1'b0;
    rd(3'd7, 1'b0, s); eq("R13 ready/fault bits back", {s[6], s[5]}, 2'b10);
  endtask

  initial begin
    #1_500_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: act=%0d exp=0", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_regs();
    t_seek();
    t_rate();
    t_restore();
    t_scan();
    t_timeout();
    t_read_single();
    t_read_multi();
    t_write_multi();
    t_invalid();
    t_lines();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule